// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block chooses which of N resident slots (cache ways or page frames) to evict when a new item has to come in. Each slot keeps one use flag. A hit on a slot raises its flag. A circular pointer, the sweep hand, moves over the slots only while a fault is being serviced.

When a slot under the hand has its flag raised, the block lowers the flag and steps on. That slot survives this pass, so it gets one more chance. The first slot found with a lowered flag is the victim. The new occupant goes into that slot with its flag raised, and the hand moves one slot past it. With no hits at all, slots are handed out in plain arrival order.

A fault request is accepted only while the selector is idle. The answer is a one-cycle `victimValid` pulse that carries the slot number. The block holds no tags or data. It keeps only the flags and the hand.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset the hand is at slot 0, all use flags are low, `victimValid` is low and `busy` is low.
- R2: A cycle with `hitValid` high raises the use flag of slot `hitIdx`. That slot is then passed over, once, by the next sweep that reaches it.
- R3: In a sweep cycle where the slot under the hand has its flag raised, the block lowers that flag and moves the hand to the next slot, wrapping from N-1 to 0.
- R4: The victim is the first slot, starting at the hand, whose flag is low. The victim's flag is raised as the new occupant is installed, and the hand moves to the slot after the victim.
- R5: With no hits, successive faults return slots 0, 1, …, N-1 in order and then wrap around.
- R6: If every flag is raised when a fault starts, the sweep lowers all N flags and then selects the slot where the hand started. `victimValid` rises N+2 cycles after the request cycle.
- R7: When a hit on a slot lands in the same cycle as the hand lowers that slot's flag, the hit wins and the flag stays raised.
- R8: `victimValid` is high for exactly one cycle per accepted request. `faultReq` is ignored while `busy` is high.
- R9: The latency from the request cycle to `victimValid` is 2 cycles plus one cycle for each flagged slot the hand passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hitValid | input | 1 | Marks slot `hitIdx` as used this cycle |
| hitIdx | input | IDX_W | Slot that was hit |
| faultReq | input | 1 | Asks for a victim; accepted only when idle |
| busy | output | 1 | A sweep is in progress |
| victimValid | output | 1 | One-cycle pulse: `victimIdx` holds the choice |
| victimIdx | output | IDX_W | Chosen victim slot |

## Verification
The bench aims at the slow path and at the races. A fault is issued with every flag raised. A design with a wrong sweep bound, or one that gave up at the start slot early, would return the wrong slot or report the wrong latency.

A hit is timed to land in the very cycle the hand lowers that slot's flag. A design that let the clear win would evict the freshly used slot one lap early.

Extra requests are pulsed while the block is busy. A design that accepted them would emit a second victim pulse, or would move the hand, and both show up in later choices.

Plain in-order faults after reset check the FIFO order and the wrap of the hand. Random hits mixed with faults are compared against a slot-by-slot model of the sweep.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweepState_t;

  // strobes from control to datapath, all acting on the slot under the hand
  typedef struct packed {
    logic clearAtHand;   // lower the flag of the slot under the hand
    logic installAtHand; // raise the flag of the slot under the hand (new occupant)
    logic advanceHand;   // step the hand to the next slot
    logic emitVictim;    // capture the hand as victim and pulse valid
  } ctrlStrobe_t;

endpackage

// File: rtl/clock_victim_dp.sv
module clock_victim_dp
  import clock_victim_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic             hitValid,
  input  logic [IDX_W-1:0] hitIdx,
  output logic             handFlag,
  output logic [IDX_W-1:0] handPos,
  output logic [NUM_SLOTS-1:0] useFlags,
  output logic             victimValid,
  output logic [IDX_W-1:0] victimIdx
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_SLOTS - 1);

  logic [IDX_W-1:0] handNext;

  always_comb begin
    if (handPos == LAST_SLOT) handNext = '0;
    else                      handNext = handPos + IDX_W'(1);
  end

  assign handFlag = useFlags[handPos];

  // one flag per slot; hit has priority over the sweep clear
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_flag
    logic atHand;
    logic hitHere;
    assign atHand  = (handPos == IDX_W'(i));
    assign hitHere = hitValid && (hitIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        useFlags[i] <= 1'b0;
      end else if (hitHere || (atHand && strobe.installAtHand)) begin
        useFlags[i] <= 1'b1;
      end else if (atHand && strobe.clearAtHand) begin
        useFlags[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      handPos <= '0;
    end else if (strobe.advanceHand) begin
      handPos <= handNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victimValid <= 1'b0;
      victimIdx   <= '0;
    end else begin
      victimValid <= strobe.emitVictim;
      if (strobe.emitVictim) victimIdx <= handPos;
    end
  end

endmodule

// File: rtl/clock_victim_ctrl.sv
module clock_victim_ctrl
  import clock_victim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        faultReq,
  input  logic        handFlag,
  output ctrlStrobe_t strobe,
  output logic        busy
);

  sweepState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (faultReq) stateNext = ST_SWEEP;
      end
      ST_SWEEP: begin
        strobe.advanceHand = 1'b1;
        if (handFlag) begin
          strobe.clearAtHand = 1'b1;
        end else begin
          strobe.installAtHand = 1'b1;
          strobe.emitVictim    = 1'b1;
          stateNext            = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busy = (state == ST_SWEEP);

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
  import clock_victim_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hitValid,
  input  logic [IDX_W-1:0] hitIdx,
  input  logic             faultReq,
  output logic             busy,
  output logic             victimValid,
  output logic [IDX_W-1:0] victimIdx
);

  ctrlStrobe_t            strobe;
  logic                   handFlag;
  logic [IDX_W-1:0]       handPos;
  logic [NUM_SLOTS-1:0]   useFlags;

  clock_victim_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .faultReq (faultReq),
    .handFlag (handFlag),
    .strobe   (strobe),
    .busy     (busy)
  );

  clock_victim_dp #(.NUM_SLOTS(NUM_SLOTS)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .hitValid    (hitValid),
    .hitIdx      (hitIdx),
    .handFlag    (handFlag),
    .handPos     (handPos),
    .useFlags    (useFlags),
    .victimValid (victimValid),
    .victimIdx   (victimIdx)
  );

endmodule

// File: rtl/clock_victim_chk.sv
module clock_victim_chk #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hitValid,
  input logic [IDX_W-1:0]     hitIdx,
  input logic                 faultReq,
  input logic                 busy,
  input logic                 victimValid,
  input logic [IDX_W-1:0]     victimIdx,
  input logic [IDX_W-1:0]     handPos,
  input logic [NUM_SLOTS-1:0] useFlags
);

  logic             outOfReset;
  logic [IDX_W+1:0] sweepCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outOfReset <= 1'b0;
      sweepCnt   <= '0;
    end else begin
      outOfReset <= 1'b1;
      if (busy && !hitValid) sweepCnt <= sweepCnt + 1'b1;
      else                   sweepCnt <= '0;
    end
  end

  // R1: state held by reset
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (handPos == '0 && useFlags == '0 && !victimValid && !busy));

  // R4: the victim carries the new occupant's raised flag, and the hand sits just past it
  p_victim_installed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |-> (useFlags[victimIdx] &&
                     handPos == ((victimIdx == IDX_W'(NUM_SLOTS-1)) ? '0 : victimIdx + IDX_W'(1))));

  // R2, R7: a hit always leaves the flag raised, whatever the sweep did
  p_hit_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outOfReset && hitValid) |=> useFlags[$past(hitIdx)]);

  // R8: single-cycle pulse
  p_victim_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |=> !victimValid);

  // R8: a sweep only starts from an idle request, and ends with a victim
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outOfReset && $rose(busy)) |-> $past(faultReq));

  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outOfReset && $fell(busy)) |-> victimValid);

  // R6: without hits a sweep takes at most N+1 cycles
  p_sweep_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sweepCnt <= (IDX_W+2)'(NUM_SLOTS)));

endmodule

bind clock_victim_sel clock_victim_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hitValid    (hitValid),
  .hitIdx      (hitIdx),
  .faultReq    (faultReq),
  .busy        (busy),
  .victimValid (victimValid),
  .victimIdx   (victimIdx),
  .handPos     (handPos),
  .useFlags    (useFlags)
);

// File: tb/tb_clock_victim_sel.sv
`timescale 1ns/1ps
module tb_clock_victim_sel;

  localparam int N     = 8;
  localparam int IDX_W = $clog2(N);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             hitValid;
  logic [IDX_W-1:0] hitIdx;
  logic             faultReq;
  logic             busy;
  logic             victimValid;
  logic [IDX_W-1:0] victimIdx;

  int checks = 0;
  int fails  = 0;

  // bench model of the flags and the hand
  bit mFlag [N];
  int mHand;

  always #2.5 clk = ~clk;

  clock_victim_sel #(.NUM_SLOTS(N)) dut (
    .clk(clk), .rst_n(rst_n), .hitValid(hitValid), .hitIdx(hitIdx),
    .faultReq(faultReq), .busy(busy), .victimValid(victimValid), .victimIdx(victimIdx)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // model one sweep; an optional hit lands in the first sweep cycle after the clear
  task automatic modelSweep(input bit hitFirst, input int hIdx,
                            output int expVictim, output int expLat);
    int cyc = 0;
    expVictim = -1;
    while (expVictim < 0) begin
      if (mFlag[mHand]) begin
        mFlag[mHand] = 0;
        if (cyc == 0 && hitFirst) mFlag[hIdx] = 1;
        mHand = (mHand + 1) % N;
      end else begin
        expVictim = mHand;
        mFlag[mHand] = 1;
        if (cyc == 0 && hitFirst) mFlag[hIdx] = 1;
        mHand = (mHand + 1) % N;
      end
      cyc++;
    end
    expLat = cyc + 1;
  endtask

  task automatic doHit(input int idx);
    @(negedge clk);
    hitValid = 1'b1;
    hitIdx   = IDX_W'(idx);
    @(negedge clk);
    hitValid = 1'b0;
    mFlag[idx] = 1;
  endtask

  // issue a fault; extraReq pulses faultReq in sweep cycles 2 and 3 (R8)
  task automatic doFault(input string req, input bit hitFirst, input int hIdx,
                         input bit extraReq);
    int expV, expL, lat, pulses, vSeen;
    modelSweep(hitFirst, hIdx, expV, expL);
    @(negedge clk);
    faultReq = 1'b1;
    @(negedge clk);
    faultReq = 1'b0;
    lat = 1;
    if (hitFirst) begin
      hitValid = 1'b1;
      hitIdx   = IDX_W'(hIdx);
    end
    if (extraReq) check({req, " R8 busy during sweep"}, int'(busy), 1);
    pulses = 0;
    vSeen  = -1;
    for (int k = 0; k < N + 8; k++) begin
      if (victimValid) begin
        pulses++;
        if (vSeen < 0) begin
          vSeen = int'(victimIdx);
          check({req, " R9 latency"}, lat, expL);
        end
      end
      if (!extraReq && pulses > 0) break;
      @(negedge clk);
      hitValid = 1'b0;
      faultReq = extraReq && (lat == 1 || lat == 2);
      lat++;
    end
    faultReq = 1'b0;
    if (vSeen < 0) begin
      fails++; checks++;
      $display("FAIL %s: watchdog, no victimValid, expected %0d", req, expV);
    end else begin
      check({req, " R4 victim"}, vSeen, expV);
    end
    if (extraReq) check({req, " R8 pulse count"}, pulses, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finishRun();
  end

  initial begin
    rst_n = 1'b0; hitValid = 1'b0; hitIdx = '0; faultReq = 1'b0;
    for (int i = 0; i < N; i++) mFlag[i] = 0;
    mHand = 0;
    void'($urandom(32'd20250601));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 victimValid after reset", int'(victimValid), 0);
    check("R1 busy after reset", int'(busy), 0);

    // R1/R5: fresh slots are handed out in order, latency 2 each
    for (int i = 0; i < N; i++) doFault("R5 in-order fill", 0, 0, 0);

    // R6: every flag raised; extra requests while busy must be ignored (R8)
    doFault("R6 all flags set", 0, 0, 1);

    // R2/R3: a used slot is skipped once
    doHit(2);
    doHit(3);
    doFault("R3 skip used slots", 0, 0, 0);
    doFault("R2 next after skip", 0, 0, 0);

    // R7: a hit lands as the hand lowers that slot's flag
    doHit(mHand);
    doFault("R7 hit beats clear", 1, mHand, 0);
    for (int i = 0; i < 2 * N; i++) doFault("R7 follow-up", 0, 0, 0);

    // random hits mixed with faults
    for (int it = 0; it < 200; it++) begin
      int nh = $urandom_range(0, 3);
      for (int h = 0; h < nh; h++) doHit($urandom_range(0, N - 1));
      if ($urandom_range(0, 7) == 0) doFault("R7 random race", 1, $urandom_range(0, N - 1), 0);
      else                           doFault("R4 random", 0, 0, 0);
    end

    repeat (3) @(negedge clk);
    check("R8 idle at end", int'(busy), 0);
    finishRun();
  end

endmodule